// File: doc/BRIEF.md
# Command Packet Framer

The framer sits on the command word port of a drawing engine. Each 32-bit word arriving on the input is collected into a packet whose first word carries an opcode in bits 31:24. The opcode fixes how many parameter words follow it. Once the last word of a packet is in, the framer replays the whole packet to the renderer, one word per cycle, with start and end markers. While a packet is still incomplete, its words stay in an internal buffer.

Along the way the framer keeps eight environment words. Some of them are loaded by dedicated opcodes, and the texture-page field is picked up from inside textured primitives. It drives a 13-bit status field built from two of these words. It also raises a sticky flag once any drawing packet has gone through. An image write or image read opcode is not forwarded. Its position and size words go to a separate transfer sequencer, and input is refused until that sequencer reports completion.

Top module: `cmd_framer`

## Requirements
- R1: After reset, in_ready is 1, pkt_valid, xfer_start and fb_dirty are 0, status is 0, and environment word i reads back as {8'hE0+i, 24'h0}.
- R2: A packet holds 1 + N words, where N is set by the opcode. N is 2 for 02, 40-47, 60-63, 74-77, 7C-7F, A0 and C0. N is 3 for 20-23, 48-4F, 50-57, 64-67 and 80. N is 1 for 68-6B, 70-73 and 78-7B. N is 4 for 28-2B and 58-5F. N is 5 for 30-33, 6 for 24-27, 7 for 38-3B, 8 for 2C-2F and 34-37, and 11 for 3C-3F. N is 0 for every other opcode.
- R3: In the cycle after the last word of a non-image packet is accepted, pkt_valid rises and the packet words appear in arrival order, one per cycle and without gaps. pkt_sop marks the first word and pkt_eop the last. in_ready is 0 during this replay and returns to 1 the cycle after pkt_eop.
- R4: Idle input cycles inside a packet are allowed. Nothing is emitted until the final word arrives.
- R5: A completed packet with opcode E0-E7 stores its whole first word into environment word (opcode & 7).
- R6: A completed packet whose opcode satisfies (op & F4) == 24 copies bits 8:0 of its word 4 (word 0 being the opcode word) into bits 8:0 of environment word 1. The other bits are kept.
- R7: A completed packet whose opcode satisfies (op & F4) == 34 does the same with bits 8:0 of its word 5.
- R8: status[10:0] equals environment word 1 bits 10:0, and status[12:11] equals environment word 6 bits 1:0.
- R9: fb_dirty becomes 1 when a packet with opcode from 02 to BF completes, and then stays 1 until reset. Other opcodes leave it unchanged.
- R10: Completing an A0 (write) or C0 (read) packet emits nothing on the packet port. Instead, xfer_start pulses for one cycle in the cycle after the size word is accepted. At that point xfer_pos holds word 1, xfer_size holds word 2, and xfer_read is 1 only for C0. in_ready stays 0 from that cycle until the cycle after xfer_done is sampled high.
- R11: xfer_done has no effect when no transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Framer accepts a word this cycle |
| pkt_valid | output | 1 | Packet word on pkt_data |
| pkt_sop | output | 1 | First word of packet |
| pkt_eop | output | 1 | Last word of packet |
| pkt_data | output | 32 | Packet word to renderer |
| xfer_start | output | 1 | One-cycle transfer launch |
| xfer_read | output | 1 | Transfer direction, 1 = read from video memory |
| xfer_pos | output | 32 | Position word of the transfer |
| xfer_size | output | 32 | Size word of the transfer |
| xfer_done | input | 1 | Transfer sequencer finished |
| env_sel | input | 3 | Environment word select |
| env_word | output | 32 | Selected environment word |
| status | output | 13 | Mirrored environment state |
| fb_dirty | output | 1 | Drawing has occurred since reset |

## Verification
A word accepted on one rising edge leaves its mark one cycle later. Environment words, status and fb_dirty change together with the final word of a packet. The replay starts in the next cycle and lasts exactly as many cycles as the packet has words. xfer_start shows up in the cycle after the size word. The bench runs a behavioural model that takes the same one-edge step and compares every output at each falling edge, so each result is sampled in the cycle it falls due. Idle gaps on the input and stray xfer_done pulses are mixed in, which exercises the hold and ignore cases.

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int MAX_WORDS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        pkt_valid,
  output logic        pkt_sop,
  output logic        pkt_eop,
  output logic [31:0] pkt_data,
  output logic        xfer_start,
  output logic        xfer_read,
  output logic [31:0] xfer_pos,
  output logic [31:0] xfer_size,
  input  logic        xfer_done,
  input  logic [2:0]  env_sel,
  output logic [31:0] env_word,
  output logic [12:0] status,
  output logic        fb_dirty
);
  localparam int CW = $clog2(MAX_WORDS + 1);

  typedef enum logic [1:0] {COLLECT, EMIT, XFER} st_t;

  function automatic logic [3:0] extra_words(input logic [7:0] op);
    casez (op)
      8'h02:        return 4'd2;
      8'b0010_00??: return 4'd3;
      8'b0010_01??: return 4'd6;
      8'b0010_10??: return 4'd4;
      8'b0010_11??: return 4'd8;
      8'b0011_00??: return 4'd5;
      8'b0011_01??: return 4'd8;
      8'b0011_10??: return 4'd7;
      8'b0011_11??: return 4'd11;
      8'b0100_0???: return 4'd2;
      8'b0100_1???: return 4'd3;
      8'b0101_0???: return 4'd3;
      8'b0101_1???: return 4'd4;
      8'b0110_00??: return 4'd2;
      8'b0110_01??: return 4'd3;
      8'b0110_10??: return 4'd1;
      8'b0111_00??: return 4'd1;
      8'b0111_01??: return 4'd2;
      8'b0111_10??: return 4'd1;
      8'b0111_11??: return 4'd2;
      8'h80:        return 4'd3;
      8'hA0:        return 4'd2;
      8'hC0:        return 4'd2;
      default:      return 4'd0;
    endcase
  endfunction

  st_t            st;
  logic [31:0]    buf_q [MAX_WORDS];
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  idx;
  logic [3:0]     need;
  logic [31:0]    env [8];

  logic [31:0] head_word;
  logic [7:0]  op;
  logic [3:0]  need_now;
  logic        accept, last, is_img;

  assign head_word = (cnt == '0) ? in_data : buf_q[0];
  assign op        = head_word[31:24];
  assign need_now  = (cnt == '0) ? extra_words(op) : need;
  assign accept    = (st == COLLECT) && in_valid;
  assign last      = accept && (cnt == CW'(need_now));
  assign is_img    = (op == 8'hA0) || (op == 8'hC0);

  assign in_ready  = (st == COLLECT);
  assign pkt_valid = (st == EMIT);
  assign pkt_sop   = pkt_valid && (idx == '0);
  assign pkt_eop   = pkt_valid && (idx == CW'(need));
  assign pkt_data  = buf_q[idx];
  assign env_word  = env[env_sel];
  assign status    = {env[6][1:0], env[1][10:0]};

  always_ff @(posedge clk)
    if (accept) buf_q[cnt] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= COLLECT;
      cnt        <= '0;
      idx        <= '0;
      need       <= '0;
      fb_dirty   <= 1'b0;
      xfer_start <= 1'b0;
      xfer_read  <= 1'b0;
      xfer_pos   <= '0;
      xfer_size  <= '0;
      for (int i = 0; i < 8; i++) env[i] <= {8'hE0 + 8'(i), 24'h0};
    end else begin
      xfer_start <= 1'b0;
      case (st)
        COLLECT: if (accept) begin
          if (cnt == '0) need <= need_now;
          if (last) begin
            cnt <= '0;
            if (op[7:3] == 5'b11100) env[op[2:0]] <= head_word;
            if ((op & 8'hF4) == 8'h24) env[1][8:0] <= buf_q[4][8:0];
            if ((op & 8'hF4) == 8'h34) env[1][8:0] <= buf_q[5][8:0];
            if (op >= 8'h02 && op < 8'hC0) fb_dirty <= 1'b1;
            if (is_img) begin
              st         <= XFER;
              xfer_start <= 1'b1;
              xfer_pos   <= buf_q[1];
              xfer_size  <= in_data;
              xfer_read  <= (op == 8'hC0);
            end else begin
              st  <= EMIT;
              idx <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EMIT: begin
          if (idx == CW'(need)) st <= COLLECT;
          else idx <= idx + 1'b1;
        end
        XFER: if (xfer_done) st <= COLLECT;
        default: st <= COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/cmd_framer_checker.sv
module cmd_framer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        pkt_valid,
  input logic        pkt_sop,
  input logic        pkt_eop,
  input logic        xfer_start,
  input logic        fb_dirty,
  input logic [2:0]  env_sel,
  input logic [31:0] env_word,
  input logic [12:0] status
);
  assert_replay_stalls_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !in_ready);
  assert_eop_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_eop) |=> (!pkt_valid && in_ready));
  assert_replay_gapless_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_eop) |=> (pkt_valid && !pkt_sop));
  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_start_holds_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (!in_ready && !pkt_valid));
  assert_dirty_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_dirty |=> fb_dirty);
  assert_status_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (env_sel == 3'd1) |-> (status[10:0] == env_word[10:0]));
endmodule

bind cmd_framer cmd_framer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pkt_valid(pkt_valid),
  .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .xfer_start(xfer_start),
  .fb_dirty(fb_dirty), .env_sel(env_sel), .env_word(env_word), .status(status)
);

// File: tb/cmd_framer_bench.sv
module cmd_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 20000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, xfer_done = 0;
  logic [31:0] in_data = 0;
  logic [2:0] env_sel = 0;
  logic in_ready, pkt_valid, pkt_sop, pkt_eop, xfer_start, xfer_read, fb_dirty;
  logic [31:0] pkt_data, xfer_pos, xfer_size, env_word;
  logic [12:0] status;

  cmd_framer u_cmd_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .pkt_data(pkt_data), .xfer_start(xfer_start),
    .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .xfer_done(xfer_done), .env_sel(env_sel), .env_word(env_word),
    .status(status), .fb_dirty(fb_dirty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  bit running = 0, gaps = 0;
  logic [31:0] drvq[$];

  int ph = 0, eidx = 0, xw = 0;
  logic [31:0] q[$], eq[$];
  logic [31:0] menv [8];
  bit mdirty = 0, mxs = 0, mxrd = 0;
  logic [31:0] mxpos = 0, mxsize = 0;

  function automatic int extra(input logic [7:0] op);
    if (op == 8'h02 || op == 8'hA0 || op == 8'hC0) return 2;
    if (op == 8'h80) return 3;
    if (op inside {[8'h20:8'h23]}) return 3;
    if (op inside {[8'h24:8'h27]}) return 6;
    if (op inside {[8'h28:8'h2B]}) return 4;
    if (op inside {[8'h2C:8'h2F]}) return 8;
    if (op inside {[8'h30:8'h33]}) return 5;
    if (op inside {[8'h34:8'h37]}) return 8;
    if (op inside {[8'h38:8'h3B]}) return 7;
    if (op inside {[8'h3C:8'h3F]}) return 11;
    if (op inside {[8'h40:8'h47]}) return 2;
    if (op inside {[8'h48:8'h57]}) return 3;
    if (op inside {[8'h58:8'h5F]}) return 4;
    if (op inside {[8'h60:8'h63]}) return 2;
    if (op inside {[8'h64:8'h67]}) return 3;
    if (op inside {[8'h68:8'h6B]}) return 1;
    if (op inside {[8'h70:8'h73]}) return 1;
    if (op inside {[8'h74:8'h77]}) return 2;
    if (op inside {[8'h78:8'h7B]}) return 1;
    if (op inside {[8'h7C:8'h7F]}) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic pkt(input logic [31:0] head, input logic [31:0] seed);
    drvq.push_back(head);
    for (int k = 1; k <= extra(head[31:24]); k++) drvq.push_back(seed + 32'(k));
  endtask

  task automatic drain();
    int idle = 0;
    while (idle < 4 && cyc < LIMIT) begin
      @(negedge clk);
      if (drvq.size() == 0 && ph == 0) idle++; else idle = 0;
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      chk("R3 R10 R11", "in_ready", 32'(in_ready), 32'(ph == 0));
      chk("R4", "pkt_valid", 32'(pkt_valid), 32'(ph == 1));
      if (ph == 1) begin
        chk("R3", "pkt_data", pkt_data, eq[0]);
        chk("R3", "pkt_sop", 32'(pkt_sop), 32'(eidx == 0));
        chk("R2", "pkt_eop", 32'(pkt_eop), 32'(eq.size() == 1));
      end
      chk("R10", "xfer_start", 32'(xfer_start), 32'(mxs));
      if (mxs) begin
        chk("R10", "xfer_pos", xfer_pos, mxpos);
        chk("R10", "xfer_size", xfer_size, mxsize);
        chk("R10", "xfer_read", 32'(xfer_read), 32'(mxrd));
      end
      chk("R8", "status", 32'(status), 32'({menv[6][1:0], menv[1][10:0]}));
      chk("R5 R6 R7", "env_word", env_word, menv[env_sel]);
      chk("R9", "fb_dirty", 32'(fb_dirty), 32'(mdirty));

      env_sel  = 3'(cyc);
      in_valid = (drvq.size() > 0) && !(gaps && (cyc % 3 == 1));
      in_data  = in_valid ? drvq[0] : 32'hDEAD_BEEF;
      if (ph == 2) begin xw++; xfer_done = (xw >= 3); end
      else xfer_done = (cyc % 7 == 0);   // R11: stray completion pulses

      mxs = 0;
      case (ph)
        0: if (in_valid) begin
          logic [7:0] op;
          q.push_back(in_data);
          void'(drvq.pop_front());
          op = q[0][31:24];
          if (q.size() == 1 + extra(op)) begin
            if (op[7:3] == 5'b11100) menv[op[2:0]] = q[0];
            if ((op & 8'hF4) == 8'h24) menv[1][8:0] = q[4][8:0];
            if ((op & 8'hF4) == 8'h34) menv[1][8:0] = q[5][8:0];
            if (op >= 8'h02 && op < 8'hC0) mdirty = 1;
            if (op == 8'hA0 || op == 8'hC0) begin
              ph = 2; mxs = 1; mxpos = q[1]; mxsize = q[2]; mxrd = (op == 8'hC0); xw = 0;
            end else begin
              eq = q; eidx = 0; ph = 1;
            end
            q.delete();
          end
        end
        1: begin
          void'(eq.pop_front());
          eidx++;
          if (eq.size() == 0) ph = 0;
        end
        default: if (xfer_done) ph = 0;
      endcase
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) menv[i] = {8'hE0 + 8'(i), 24'h0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "pkt_valid", 32'(pkt_valid), 32'd0);
    chk("R1", "xfer_start", 32'(xfer_start), 32'd0);
    chk("R1", "status", 32'(status), 32'd0);
    chk("R1", "fb_dirty", 32'(fb_dirty), 32'd0);
    for (int i = 0; i < 8; i++) begin
      env_sel = 3'(i);
      #1 chk("R1", "env_word", env_word, {8'hE0 + 8'(i), 24'h0});
    end
    running = 1;

    // R9: non-drawing opcodes first, dirty must stay low
    pkt(32'h0000_0000, 0);
    pkt(32'h0100_0000, 0);
    pkt(32'hFF00_0000, 0);
    pkt(32'hE100_05A3, 0);          // R5, R8
    pkt(32'hE600_0002, 0);          // R8 bits 12:11
    pkt(32'hC000_0000, 32'h0010_0020); // R10 read, not dirty
    drain();
    pkt(32'hE312_3456, 0);          // R5
    pkt(32'hE7AB_CDEF, 0);
    gaps = 1;                       // R4 idle gaps inside packets
    pkt(32'h2012_3456, 32'h1000_0000);
    pkt(32'h2400_0000, 32'h0000_01F0); // R6
    pkt(32'h3400_0000, 32'h0000_0A00); // R7
    pkt(32'h3C00_0000, 32'h2000_0000); // R2 longest packet
    pkt(32'h0200_0000, 32'h3000_0000);
    pkt(32'h6000_0000, 32'h4000_0000);
    pkt(32'h6800_0000, 32'h5000_0000);
    pkt(32'h8000_0000, 32'h6000_0000);
    pkt(32'h4500_0000, 32'h7000_0000);
    pkt(32'h5A00_0000, 32'h7100_0000);
    pkt(32'h7C00_0000, 32'h7200_0000);
    pkt(32'h1F00_0000, 0);
    pkt(32'hA000_0000, 32'h0033_0044); // R10 write
    pkt(32'hE100_0000, 0);
    pkt(32'h2700_0000, 32'h0000_0FF8); // R6 keeps upper env bits
    gaps = 0;
    pkt(32'h3600_0000, 32'h0000_0111); // R7
    pkt(32'hC000_0000, 32'h0001_0002);
    drain();
    if (cyc >= LIMIT) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule